// File: doc/BRIEF.md
# Synchronous Burst SRAM Core

This block is a single-clock static memory with a four-lane data word; each lane holds eight data bits and one parity bit. Every rising clock edge it decides what kind of cycle to run from its sampled controls: a new access started by one of two address strobes (a processor-side strobe and a controller-side strobe), a burst step requested through an advance input, a hold on the current address, or nothing at all. Writes can cover the whole word through a global write input, or any subset of lanes through a byte-write enable and four per-lane selects. A lane's parity bit is always written together with that lane's data.

Reads are pipelined. The address is registered on one edge, and the word is presented after the following edge. The shared data bus is modelled as separate write-data and read-data ports plus a drive-enable output, which a pad wrapper turns into one bidirectional bus. The drive enable depends on the kind of cycle that produced the word. It is also gated at once by an asynchronous output enable and by a sleep input, and it stays off when the chip is deselected and after writes. A two-bit burst counter steps through four addresses in either linear or interleaved order, selected by a static input. Storage depth is set by a parameter.

Top module: `sync_burst_sram`

## Requirements
- R1: When global write is high and byte-write enable is low, lane i (bits 9*i+8 down to 9*i, with bit 9*i+8 as its parity) is written exactly when select bwN[i] is low, and all other lanes keep their contents.
- R2: When global write is low in a write cycle, all 36 bits are written, whatever the byte-write enable and the lane selects are.
- R3: A controller-strobe cycle with global write and byte-write enable both high is a read. A write cycle with byte-write enable low and all four selects high changes no storage and drives nothing.
- R4: A cycle started by the processor strobe is always a read and ignores every write control. When both strobes are low, the processor strobe takes priority.
- R5: A read whose address is registered at edge k drives the word after edge k+1, provided output enable is low and sleep is low. Nothing is driven after reset.
- R6: When advance is low and no strobe is active during a burst, the two low address bits step. In linear order (interleave=0) they become base+n modulo 4; in interleaved order (interleave=1) they become base XOR n. They wrap after four steps, and the upper address bits never change.
- R7: With no strobe and advance high, the burst holds its address. After a read this re-reads the word. After a write with no write controls active it does nothing and drives nothing. With write controls active it writes the held address.
- R8: After a write cycle at edge k, nothing is driven between edges k+1 and k+2.
- R9: A strobe while chip enable 1 is high, chip enable 2 is low or chip enable 3 is high deselects the block. No access takes place, nothing is driven two edges later, and later advance cycles do nothing until a new strobe arrives.
- R10: Output enable is asynchronous: while it is high, nothing is driven, without waiting for a clock edge.
- R11: While sleep is high, nothing is driven and no write takes place. After sleep falls, nothing is driven until a new read has passed through the pipeline.
- R12: Reads and writes to different addresses may follow each other on consecutive clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| addr | input | ADDR_W | Word address, captured by a strobe |
| ce1N | input | 1 | Chip enable 1, active low |
| ce2 | input | 1 | Chip enable 2, active high |
| ce3N | input | 1 | Chip enable 3, active low |
| adsProcN | input | 1 | Processor-side address strobe, active low |
| adsCtrlN | input | 1 | Controller-side address strobe, active low |
| advN | input | 1 | Burst advance, active low |
| gwN | input | 1 | Global write, active low |
| bweN | input | 1 | Byte-write enable, active low |
| bwN | input | 4 | Per-lane write selects, active low |
| oeN | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Sleep, active high |
| interleave | input | 1 | Burst order: 1 interleaved, 0 linear |
| dataIn | input | 36 | Write data, four 9-bit lanes |
| dataOut | output | 36 | Read data |
| dataOutEn | output | 1 | Read data is being driven onto the bus |

## Verification
The hardest state to reach from the ports is one where the drive enable hinges on history. Examples are a hold cycle after a write with the write controls released, an advance after a deselect, and the first cycles after sleep falls. Each of these needs a particular order of two or three cycles, so uniform random stimulus rarely produces them. The bench writes these orders out as directed sequences. It then runs a long seeded random mix of strobes, advances, holds, deselects, sleep pulses and lane patterns over a small address window, so that bursts overlap and words are written and read often. Every cycle is compared with a reference model of the memory and pipeline kept in the bench.

// File: rtl/sbs_pkg.sv
package sbs_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 9;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    MODE_IDLE  = 2'd0,
    MODE_READ  = 2'd1,
    MODE_WRITE = 2'd2
  } accMode_t;

  // strobes from the cycle decoder to the address and storage datapath
  typedef struct packed {
    logic             loadAddr;
    logic             advance;
    logic             doRead;
    logic             doWrite;
    logic [LANES-1:0] laneWe;
  } accStrobe_t;
endpackage

// File: rtl/sbs_ctrl.sv
module sbs_ctrl
  import sbs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             ce1N,
  input  logic             ce2,
  input  logic             ce3N,
  input  logic             adsProcN,
  input  logic             adsCtrlN,
  input  logic             advN,
  input  logic             gwN,
  input  logic             bweN,
  input  logic [LANES-1:0] bwN,
  input  logic             sleep,
  output accStrobe_t       strobe
);
  accMode_t         modeQ, modeNext;
  logic             chipSel, wantWrite, anyStart;
  logic [LANES-1:0] laneSel;

  always_comb begin
    chipSel   = !ce1N && ce2 && !ce3N;
    wantWrite = !gwN || !bweN;
    anyStart  = !adsProcN || !adsCtrlN;
    if (!gwN)       laneSel = '1;
    else if (!bweN) laneSel = ~bwN;
    else            laneSel = '0;
  end

  always_comb begin
    strobe   = '0;
    modeNext = modeQ;
    if (sleep) begin
      modeNext = MODE_IDLE;
    end else if (anyStart) begin
      if (!chipSel) begin
        modeNext = MODE_IDLE;
      end else begin
        strobe.loadAddr = 1'b1;
        // processor strobe wins and always reads
        if (!adsProcN || !wantWrite) begin
          strobe.doRead = 1'b1;
          modeNext      = MODE_READ;
        end else begin
          strobe.doWrite = 1'b1;
          strobe.laneWe  = laneSel;
          modeNext       = MODE_WRITE;
        end
      end
    end else if (modeQ != MODE_IDLE) begin
      strobe.advance = !advN;
      if (wantWrite) begin
        strobe.doWrite = 1'b1;
        strobe.laneWe  = laneSel;
        modeNext       = MODE_WRITE;
      end else if (!advN || modeQ == MODE_READ) begin
        strobe.doRead = 1'b1;
        modeNext      = MODE_READ;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) modeQ <= MODE_IDLE;
    else       modeQ <= modeNext;
  end
endmodule

// File: rtl/sbs_addr.sv
module sbs_addr
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              interleave,
  output logic [ADDR_W-1:0] effAddr
);
  logic [ADDR_W-1:0]  baseQ, baseNext;
  logic [BURST_W-1:0] cntQ, cntNext, lowLin, lowIlv;

  always_comb begin
    baseNext = strobe.loadAddr ? addrIn : baseQ;
    if (strobe.loadAddr)     cntNext = '0;
    else if (strobe.advance) cntNext = cntQ + BURST_W'(1);
    else                     cntNext = cntQ;
    lowLin  = baseNext[BURST_W-1:0] + cntNext;
    lowIlv  = baseNext[BURST_W-1:0] ^ cntNext;
    effAddr = {baseNext[ADDR_W-1:BURST_W], interleave ? lowIlv : lowLin};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      baseQ <= '0;
      cntQ  <= '0;
    end else begin
      baseQ <= baseNext;
      cntQ  <= cntNext;
    end
  end
endmodule

// File: rtl/sbs_store.sv
module sbs_store
  import sbs_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  accStrobe_t        strobe,
  input  logic [ADDR_W-1:0] effAddr,
  input  logic [WORD_W-1:0] dataIn,
  input  logic              oeN,
  input  logic              sleep,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [WORD_W-1:0] rdWord, stageQ, outQ;
  logic              stageV, outV;

  for (genvar g = 0; g < LANES; g++) begin : gLane
    logic [LANE_W-1:0] laneMem [DEPTH];
    always_ff @(posedge clk) begin
      if (strobe.doWrite && strobe.laneWe[g])
        laneMem[effAddr] <= dataIn[g*LANE_W +: LANE_W];
    end
    assign rdWord[g*LANE_W +: LANE_W] = laneMem[effAddr];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stageV <= 1'b0;
      outV   <= 1'b0;
    end else if (sleep) begin
      stageV <= 1'b0;
      outV   <= 1'b0;
    end else begin
      stageV <= strobe.doRead;
      outV   <= stageV;
    end
  end

  always_ff @(posedge clk) begin
    if (strobe.doRead) stageQ <= rdWord;
    outQ <= stageQ;
  end

  assign dataOut   = outQ;
  assign dataOutEn = outV && !oeN && !sleep;
endmodule

// File: rtl/sync_burst_sram.sv
module sync_burst_sram
  import sbs_pkg::*;
#(
  parameter int ADDR_W  = 8,
  parameter int BURST_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce1N,
  input  logic              ce2,
  input  logic              ce3N,
  input  logic              adsProcN,
  input  logic              adsCtrlN,
  input  logic              advN,
  input  logic              gwN,
  input  logic              bweN,
  input  logic [LANES-1:0]  bwN,
  input  logic              oeN,
  input  logic              sleep,
  input  logic              interleave,
  input  logic [WORD_W-1:0] dataIn,
  output logic [WORD_W-1:0] dataOut,
  output logic              dataOutEn
);
  accStrobe_t        strobe;
  logic [ADDR_W-1:0] effAddr;

  sbs_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adsProcN(adsProcN), .adsCtrlN(adsCtrlN), .advN(advN),
    .gwN(gwN), .bweN(bweN), .bwN(bwN), .sleep(sleep), .strobe(strobe)
  );

  sbs_addr #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) uAddr (
    .clk(clk), .rstN(rstN), .strobe(strobe), .addrIn(addr),
    .interleave(interleave), .effAddr(effAddr)
  );

  sbs_store #(.ADDR_W(ADDR_W)) uStore (
    .clk(clk), .rstN(rstN), .strobe(strobe), .effAddr(effAddr),
    .dataIn(dataIn), .oeN(oeN), .sleep(sleep),
    .dataOut(dataOut), .dataOutEn(dataOutEn)
  );
endmodule

// File: rtl/sbs_checker.sv
module sbs_checker (
  input logic clk,
  input logic rstN,
  input logic ce1N,
  input logic ce2,
  input logic ce3N,
  input logic adsProcN,
  input logic adsCtrlN,
  input logic gwN,
  input logic bweN,
  input logic oeN,
  input logic sleep,
  input logic dataOutEn
);
  logic selC, wrStartC, procRdC, deselC;
  assign selC     = !ce1N && ce2 && !ce3N;
  assign wrStartC = !sleep && selC && adsProcN && !adsCtrlN && (!gwN || !bweN);
  assign procRdC  = !sleep && selC && !adsProcN;
  assign deselC   = !sleep && (!adsProcN || !adsCtrlN) && !selC;

  AST_OE_GATES: assert property (@(posedge clk) disable iff (!rstN)
    oeN |-> !dataOutEn); // R10
  AST_SLEEP_GATES: assert property (@(posedge clk) disable iff (!rstN)
    sleep |-> !dataOutEn); // R11
  AST_WAKE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sleep) |=> !dataOutEn); // R11
  AST_WRITE_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    wrStartC |=> ##1 !dataOutEn); // R8
  AST_DESEL_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    deselC |=> ##1 !dataOutEn); // R9
  AST_PROC_READ_DRIVES: assert property (@(posedge clk) disable iff (!rstN)
    procRdC ##1 !sleep |=> (oeN || sleep || dataOutEn)); // R5
endmodule

bind sync_burst_sram sbs_checker uChk (.*);

// File: tb/sync_burst_sram_test.sv
module sync_burst_sram_test;
  localparam int AW = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [AW-1:0] addr = '0;
  logic        ce1N = 1'b0, ce2 = 1'b1, ce3N = 1'b0;
  logic        adsProcN = 1'b1, adsCtrlN = 1'b1, advN = 1'b1;
  logic        gwN = 1'b1, bweN = 1'b1;
  logic [3:0]  bwN = 4'hF;
  logic        oeN = 1'b0, sleep = 1'b0, interleave = 1'b0;
  logic [35:0] dataIn = '0;
  logic [35:0] dataOut;
  logic        dataOutEn;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  // reference model
  logic [35:0] refMem [256];
  int          mMode = 0;      // 0 idle, 1 read, 2 write
  logic [7:0]  mBase = '0;
  logic [1:0]  mCnt = '0;
  logic [35:0] mStage = '0, mOut = '0;
  bit          mStageV = 0, mOutV = 0;

  always #4 clk = ~clk;

  sync_burst_sram #(.ADDR_W(AW), .BURST_W(2)) uut (
    .clk(clk), .rstN(rstN), .addr(addr), .ce1N(ce1N), .ce2(ce2), .ce3N(ce3N),
    .adsProcN(adsProcN), .adsCtrlN(adsCtrlN), .advN(advN), .gwN(gwN),
    .bweN(bweN), .bwN(bwN), .oeN(oeN), .sleep(sleep), .interleave(interleave),
    .dataIn(dataIn), .dataOut(dataOut), .dataOutEn(dataOutEn)
  );

  task automatic check(input bit ok, input string tag, input logic [35:0] act,
                       input logic [35:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [7:0] burstAddr(input logic [7:0] b, input logic [1:0] c,
                                           input logic ilv);
    logic [1:0] lo;
    lo = ilv ? (b[1:0] ^ c) : (b[1:0] + c);
    return {b[7:2], lo};
  endfunction

  // reference behaviour of one clock edge, from the requirements
  task automatic modelEdge();
    bit sel, wrc, rd, wr;
    logic [3:0] lanes;
    logic [7:0] a;
    sel = !ce1N && ce2 && !ce3N;
    wrc = !gwN || !bweN;
    rd = 0; wr = 0;
    lanes = !gwN ? 4'hF : (!bweN ? ~bwN : 4'h0);
    if (sleep) mMode = 0;
    else if (!adsProcN || !adsCtrlN) begin
      if (!sel) mMode = 0;
      else begin
        mBase = addr; mCnt = 2'd0;
        if (!adsProcN || !wrc) begin rd = 1; mMode = 1; end
        else begin wr = 1; mMode = 2; end
      end
    end else if (mMode != 0) begin
      if (!advN) mCnt = mCnt + 2'd1;
      if (wrc) begin wr = 1; mMode = 2; end
      else if (!advN || mMode == 1) begin rd = 1; mMode = 1; end
    end
    a = burstAddr(mBase, mCnt, interleave);
    if (sleep) begin mOutV = 0; mStageV = 0; end
    else begin
      mOut = mStage; mOutV = mStageV; mStageV = rd;
      if (rd) mStage = refMem[a];
    end
    if (wr)
      for (int i = 0; i < 4; i++)
        if (lanes[i]) refMem[a][9*i +: 9] = dataIn[9*i +: 9];
  endtask

  task automatic checkOut(input string tag);
    bit expEn;
    expEn = mOutV && !oeN && !sleep;
    check(dataOutEn === expEn, {tag, " drive"}, {35'd0, dataOutEn}, {35'd0, expEn});
    if (expEn) check(dataOut === mOut, {tag, " data"}, dataOut, mOut);
  endtask

  task automatic step(input string tag);
    @(posedge clk);
    modelEdge();
    @(negedge clk);
    checkOut(tag);
  endtask

  task automatic quiet();
    adsProcN = 1; adsCtrlN = 1; advN = 1; gwN = 1; bweN = 1; bwN = 4'hF;
    ce1N = 0; ce2 = 1; ce3N = 0; sleep = 0;
  endtask

  task automatic ctrlWrite(input logic [7:0] a, input logic [35:0] d, input logic g,
                           input logic be, input logic [3:0] bw, input string tag);
    quiet(); adsCtrlN = 0; addr = a; dataIn = d; gwN = g; bweN = be; bwN = bw;
    step(tag);
  endtask

  task automatic procRead(input logic [7:0] a, input string tag);
    quiet(); adsProcN = 0; addr = a;
    step(tag);
  endtask

  task automatic idleCyc(input string tag);
    quiet(); step(tag);
  endtask

  function automatic logic [35:0] rnd36();
    return {$urandom(), $urandom()} & 36'hF_FFFF_FFFF;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E_3D4C));
    repeat (3) @(negedge clk);
    check(dataOutEn === 1'b0, "R5 reset", {35'd0, dataOutEn}, 36'd0);
    rstN = 1;
    @(negedge clk);

    // R2 / R12: back-to-back full-word writes fill the array
    for (int i = 0; i < 256; i++)
      ctrlWrite(i[7:0], rnd36(), 1'b0, ($urandom() % 2) == 0, $urandom(), "R2 R12 fill");

    // R12 / R5: back-to-back reads
    for (int i = 0; i < 6; i++) procRead(8'(i * 7), "R12 R5 b2b read");
    idleCyc("R5 tail"); idleCyc("R5 tail");

    // R1: every lane select combination, then read back
    for (int p = 0; p < 16; p++) begin
      ctrlWrite(8'(8'h40 + p), rnd36(), 1'b1, 1'b0, 4'(p), "R1 lane write");
      procRead(8'(8'h40 + p), "R1 readback");
      idleCyc("R1 readback");
      idleCyc("R1 readback");
    end

    // R3: byte enable high is a read; all selects high writes nothing
    ctrlWrite(8'h60, rnd36(), 1'b1, 1'b1, 4'h0, "R3 read cycle");
    idleCyc("R3 read data");
    ctrlWrite(8'h61, rnd36(), 1'b1, 1'b0, 4'hF, "R3 empty write");
    idleCyc("R3 empty write off");
    procRead(8'h61, "R3 unchanged"); idleCyc("R3 unchanged"); idleCyc("R3 unchanged");

    // R4: processor strobe ignores writes and beats the controller strobe
    quiet(); adsProcN = 0; addr = 8'h62; gwN = 0; dataIn = rnd36(); step("R4 proc read");
    idleCyc("R4 drive");
    quiet(); adsProcN = 0; adsCtrlN = 0; addr = 8'h63; gwN = 0; dataIn = rnd36(); step("R4 both");
    idleCyc("R4 drive");
    procRead(8'h62, "R4 unchanged"); procRead(8'h63, "R4 unchanged");
    idleCyc("R4 unchanged"); idleCyc("R4 unchanged");

    // R6: bursts in both orders, with wrap
    for (int o = 0; o < 2; o++) begin
      interleave = o[0];
      procRead(8'h71, "R6 burst start");
      for (int k = 0; k < 5; k++) begin quiet(); advN = 0; step("R6 burst step"); end
      idleCyc("R6 tail"); idleCyc("R6 tail");
      ctrlWrite(8'h82, rnd36(), 1'b0, 1'b1, 4'hF, "R6 write burst");
      for (int k = 0; k < 3; k++) begin
        quiet(); advN = 0; gwN = 0; dataIn = rnd36(); step("R6 write step");
      end
      for (int k = 0; k < 4; k++) procRead(8'(8'h80 + k), "R6 write readback");
      idleCyc("R6 tail"); idleCyc("R6 tail");
    end
    interleave = 0;

    // R7: hold cycles
    procRead(8'h90, "R7 read");
    idleCyc("R7 hold reread"); idleCyc("R7 hold reread"); idleCyc("R7 hold reread");
    ctrlWrite(8'h91, rnd36(), 1'b0, 1'b1, 4'hF, "R7 write");
    quiet(); gwN = 0; dataIn = rnd36(); step("R7 hold write");
    idleCyc("R7 hold no access"); idleCyc("R7 hold no access");
    procRead(8'h91, "R7 readback"); idleCyc("R7 readback"); idleCyc("R7 readback");

    // R8: quiet after a write
    procRead(8'h92, "R8 read");
    ctrlWrite(8'h93, rnd36(), 1'b0, 1'b1, 4'hF, "R8 write");
    idleCyc("R8 after write"); idleCyc("R8 after write"); idleCyc("R8 after write");

    // R9: deselect ends the burst
    procRead(8'hA0, "R9 read");
    quiet(); adsCtrlN = 0; ce2 = 0; addr = 8'hA4; step("R9 deselect");
    quiet(); advN = 0; step("R9 adv ignored");
    quiet(); advN = 0; ce3N = 1; step("R9 adv ignored");
    quiet(); advN = 0; step("R9 adv ignored");
    quiet(); adsProcN = 0; ce1N = 1; addr = 8'hA5; step("R9 ce1 deselect");
    idleCyc("R9 off"); idleCyc("R9 off");

    // R10: asynchronous output enable
    procRead(8'hB0, "R10 read"); idleCyc("R10 hold");
    oeN = 1; #1;
    check(dataOutEn === 1'b0, "R10 oe high", {35'd0, dataOutEn}, 36'd0);
    oeN = 0; #1;
    check(dataOutEn === 1'b1, "R10 oe low", {35'd0, dataOutEn}, 36'd1);
    idleCyc("R10 hold");

    // R11: sleep blocks writes and output
    sleep = 1; #1;
    check(dataOutEn === 1'b0, "R11 sleep async", {35'd0, dataOutEn}, 36'd0);
    quiet(); sleep = 1; adsCtrlN = 0; addr = 8'hB0; gwN = 0; dataIn = rnd36(); step("R11 sleep write");
    quiet(); sleep = 1; step("R11 asleep");
    idleCyc("R11 wake"); idleCyc("R11 wake");
    procRead(8'hB0, "R11 unchanged"); idleCyc("R11 unchanged"); idleCyc("R11 unchanged");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = $urandom() % 12;
      quiet();
      oeN = (($urandom() % 8) == 0);
      addr = 8'($urandom() % 32);
      dataIn = rnd36();
      if (($urandom() % 50) == 0) interleave = ~interleave;
      case (r)
        0, 1: begin adsCtrlN = 0; gwN = ($urandom() % 3) == 0; bweN = 0; bwN = $urandom(); end
        2, 3: adsProcN = 0;
        4:    adsCtrlN = 0;
        5, 6: begin advN = 0; if (($urandom() % 2) == 0) begin bweN = 0; bwN = $urandom(); end end
        7:    if (($urandom() % 2) == 0) gwN = 0;
        8:    begin adsCtrlN = 0; ce2 = ($urandom() % 2); ce3N = ~ce2; end
        9:    sleep = ($urandom() % 3) == 0;
        10:   begin adsProcN = 0; adsCtrlN = 0; gwN = 0; end
        default: ;
      endcase
      step("R5 random");
    end
    oeN = 0;
    for (int i = 0; i < 32; i++) procRead(8'(i), "R5 final sweep");
    idleCyc("R5 tail"); idleCyc("R5 tail");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule